// File: doc/BRIEF.md
# Password-Guarded Memory Segment Protector

This block sits between a serial command decoder and a nonvolatile array. It decides whether each program or erase request may go ahead. The decoder hands it single-cycle strobes for the guard commands, a byte stream for access codes, and a target address with every program or erase request. One cycle later the block answers with a grant or a deny pulse. It keeps a boundary pointer and an access code of one to eight bytes. Both sit in registers that reset to factory defaults: pointer 0 and no code.

The pointer splits the array in two. Addresses below the pointer are read-only. They accept a write only after a one-shot override, and the first granted write below the boundary uses that override up. Addresses at or above the pointer are open while no code is stored. Once a code is stored the block is in secure mode, and those addresses need access granted by a correct code. In secure mode the commands that move the pointer, arm the override or load a new code also need that access. Access stays open until chip select drops after an instruction that used it.

Two state machines do the work. The command machine has three states. CS_IDLE moves to CS_MATCH on an enable-access strobe and to CS_LOAD on an accepted load strobe. Both CS_MATCH and CS_LOAD return to CS_IDLE on the end-of-code strobe. The access machine also has three states. AC_LOCKED moves to AC_OPEN when a compare matches. AC_OPEN moves to AC_SPENT when a guarded command or a guarded request uses the access. AC_SPENT moves to AC_LOCKED on a falling chip select. A failed compare returns the access machine to AC_LOCKED from any state.

Top module: `seg_guard`

## Requirements
- R1: After reset no code is stored and `secure` is 0. The pointer reads back as 0, and `gnt`, `deny` and `key_err` are 0.
- R2: A load command followed by 1 to 8 bytes (`code_vld`) and `code_end` stores those bytes as the access code. From the next cycle on, `secure` is 1.
- R3: A load that ends with zero bytes clears the stored code, and `secure` returns to 0.
- R4: A request (`req_vld`) gets exactly one of `gnt`/`deny` one cycle later. While `secure` is 0, addresses at or above the pointer are granted. Addresses below the pointer are denied unless the override is armed.
- R5: While `secure` is 1, a request at or above the pointer is granted only while access is open (states AC_OPEN or AC_SPENT). Such a grant moves access to AC_SPENT.
- R6: A pointer-write strobe that is accepted loads `wptr_val`. The pointer keeps that value until the next accepted pointer write.
- R7: An accepted override strobe lets exactly one granted request below the pointer through. The next request below the pointer is denied again.
- R8: While `secure` is 1 and access is locked, the pointer-write, override and load strobes have no effect, and each raises `key_err` one cycle later.
- R9: A read-pointer strobe makes `rd_vld` pulse one cycle later, with `rd_ptr` equal to the pointer held when the strobe was sampled.
- R10: While `secure` is 1, a compare opens access only when the byte count equals the stored length and every byte matches in order. Any other compare locks access and pulses `key_err` one cycle after `code_end`.
- R11: Access that has been used is cleared when `sel` falls. Access that is open but not yet used survives a falling `sel`.
- R12: A load of more than 8 bytes pulses `key_err` and leaves the stored code and its length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores factory defaults |
| sel | input | 1 | Chip select, active high; a falling edge ends an instruction |
| cmd_enac | input | 1 | Enable-access strobe; starts a code compare |
| cmd_load | input | 1 | Load-code strobe; starts a new code |
| code_vld | input | 1 | One code byte present on `code_byte` |
| code_byte | input | 8 | Code byte |
| code_end | input | 1 | End of the code byte sequence |
| cmd_wptr | input | 1 | Pointer-write strobe |
| wptr_val | input | AW | New pointer value |
| cmd_ovr | input | 1 | Override strobe |
| cmd_rptr | input | 1 | Read-pointer strobe |
| req_vld | input | 1 | Program or erase request |
| req_addr | input | AW | Target address of the request |
| gnt | output | 1 | Request granted (pulse) |
| deny | output | 1 | Request denied (pulse) |
| rd_vld | output | 1 | Pointer readback valid (pulse) |
| rd_ptr | output | AW | Pointer readback value |
| secure | output | 1 | 1 while a code of nonzero length is stored |
| key_err | output | 1 | Compare failure, overlong load, or guarded command refused |

## Verification
The hardest situation to reach is the end of a used access window. It needs a stored code, a compare that matches, a guarded request or command that uses the access, and then a drop of `sel`, all in that order. Access must also survive a drop of `sel` when it has not been used. Directed sequences build this chain step by step: load a code, compare correctly, make a request, drop select. They are mixed with wrong-byte, short and overlong compares. A seeded random phase then interleaves compares, loads, pointer moves and requests. In that phase a bench model tracks the pointer, the code, the override and the access state, so every grant and error is predicted.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
    typedef enum logic [1:0] {CS_IDLE, CS_MATCH, CS_LOAD} cmd_st_e;
    typedef enum logic [1:0] {AC_LOCKED, AC_OPEN, AC_SPENT} acc_st_e;
endpackage

// File: rtl/seg_guard_code_store.sv
module seg_guard_code_store #(
    parameter int NBYTES = 8,
    parameter int LW     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  stage_we,
    input  logic [LW-1:0]         stage_idx,
    input  logic [7:0]            stage_byte,
    input  logic                  commit,
    input  logic [LW-1:0]         commit_len,
    output logic [8*NBYTES-1:0]   code_flat,
    output logic [LW-1:0]         code_len
);
    // Staging bank collects a new code; commit copies it over in one cycle.
    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [7:0] stage_q;
        logic [7:0] code_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
                code_q  <= '0;
            end else begin
                if (stage_we && stage_idx == LW'(g))
                    stage_q <= stage_byte;
                if (commit)
                    code_q <= stage_q;
            end
        end
        assign code_flat[8*g +: 8] = code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            code_len <= '0;
        else if (commit)
            code_len <= commit_len;
    end
endmodule

// File: rtl/seg_guard_code_cmp.sv
module seg_guard_code_cmp #(
    parameter int NBYTES = 8,
    parameter int LW     = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  byte_vld,
    input  logic [7:0]            byte_in,
    input  logic [8*NBYTES-1:0]   code_flat,
    input  logic [LW-1:0]         code_len,
    output logic [LW-1:0]         cnt,
    output logic                  match
);
    logic       mism_q;
    logic [7:0] exp_byte;

    // Select the stored byte at the current position.
    always_comb begin
        exp_byte = '0;
        for (int i = 0; i < NBYTES; i++)
            if (cnt == LW'(i))
                exp_byte = code_flat[8*i +: 8];
    end

    // Count saturates one past the maximum so an overlong sequence stays visible.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            mism_q <= 1'b0;
        end else if (clr) begin
            cnt    <= '0;
            mism_q <= 1'b0;
        end else if (byte_vld) begin
            if (cnt < LW'(NBYTES) && byte_in != exp_byte)
                mism_q <= 1'b1;
            if (cnt <= LW'(NBYTES))
                cnt <= cnt + 1'b1;
        end
    end

    assign match = !mism_q && (cnt == code_len) && (code_len != '0);
endmodule

// File: rtl/seg_guard_perm.sv
module seg_guard_perm #(
    parameter int AW = 11
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] ptr,
    input  logic          secure,
    input  logic          acc_ok,
    input  logic          ovr_armed,
    output logic          allow,
    output logic          use_ovr,
    output logic          use_acc
);
    logic below;
    always_comb begin
        below   = addr < ptr;
        allow   = below ? ovr_armed : (secure ? acc_ok : 1'b1);
        use_ovr = below && ovr_armed;
        use_acc = !below && secure && acc_ok;
    end
endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int AW         = 11,
    parameter int CODE_BYTES = 8,
    parameter int PTR_RST    = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          cmd_enac,
    input  logic          cmd_load,
    input  logic          code_vld,
    input  logic [7:0]    code_byte,
    input  logic          code_end,
    input  logic          cmd_wptr,
    input  logic [AW-1:0] wptr_val,
    input  logic          cmd_ovr,
    input  logic          cmd_rptr,
    input  logic          req_vld,
    input  logic [AW-1:0] req_addr,
    output logic          gnt,
    output logic          deny,
    output logic          rd_vld,
    output logic [AW-1:0] rd_ptr,
    output logic          secure,
    output logic          key_err
);
    localparam int LW = $clog2(CODE_BYTES + 2);

    cmd_st_e cmd_q, cmd_d;
    acc_st_e acc_q, acc_d;
    logic [AW-1:0] ptr_q, ptr_d;
    logic          ovr_q, ovr_d;
    logic          sel_q;

    logic [8*CODE_BYTES-1:0] code_flat;
    logic [LW-1:0]           code_len;
    logic [LW-1:0]           cnt;
    logic                    match;
    logic                    cmp_clr, stage_we, commit, err_d;
    logic                    acc_ok, guard_ok, take_acc;
    logic                    allow, use_ovr, use_acc;

    assign secure   = code_len != '0;
    assign acc_ok   = acc_q != AC_LOCKED;
    assign guard_ok = !secure || acc_ok;
    assign take_acc = secure && acc_ok;

    seg_guard_code_store #(.NBYTES(CODE_BYTES), .LW(LW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .stage_we(stage_we), .stage_idx(cnt), .stage_byte(code_byte),
        .commit(commit), .commit_len(cnt),
        .code_flat(code_flat), .code_len(code_len)
    );

    seg_guard_code_cmp #(.NBYTES(CODE_BYTES), .LW(LW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clr(cmp_clr),
        .byte_vld(code_vld && cmd_q != CS_IDLE), .byte_in(code_byte),
        .code_flat(code_flat), .code_len(code_len),
        .cnt(cnt), .match(match)
    );

    seg_guard_perm #(.AW(AW)) u_perm (
        .addr(req_addr), .ptr(ptr_q), .secure(secure), .acc_ok(acc_ok),
        .ovr_armed(ovr_q), .allow(allow), .use_ovr(use_ovr), .use_acc(use_acc)
    );

    // Next-state logic for both machines and the guarded registers.
    always_comb begin
        cmd_d    = cmd_q;
        acc_d    = acc_q;
        ptr_d    = ptr_q;
        ovr_d    = ovr_q;
        cmp_clr  = 1'b0;
        stage_we = 1'b0;
        commit   = 1'b0;
        err_d    = 1'b0;

        if (sel_q && !sel && acc_q == AC_SPENT)
            acc_d = AC_LOCKED;

        unique case (cmd_q)
            CS_IDLE: ;
            CS_MATCH: begin
                if (code_end) begin
                    cmd_d = CS_IDLE;
                    if (secure) begin
                        if (match) begin
                            acc_d = AC_OPEN;
                        end else begin
                            acc_d = AC_LOCKED;
                            err_d = 1'b1;
                        end
                    end
                end
            end
            CS_LOAD: begin
                if (code_vld && cnt < LW'(CODE_BYTES))
                    stage_we = 1'b1;
                if (code_end) begin
                    cmd_d = CS_IDLE;
                    if (cnt <= LW'(CODE_BYTES))
                        commit = 1'b1;
                    else
                        err_d = 1'b1;
                end
            end
            default: cmd_d = CS_IDLE;
        endcase

        if (cmd_enac) begin
            cmd_d   = CS_MATCH;
            cmp_clr = 1'b1;
        end
        if (cmd_load) begin
            if (guard_ok) begin
                cmd_d   = CS_LOAD;
                cmp_clr = 1'b1;
                if (take_acc) acc_d = AC_SPENT;
            end else begin
                err_d = 1'b1;
            end
        end
        if (cmd_wptr) begin
            if (guard_ok) begin
                ptr_d = wptr_val;
                if (take_acc) acc_d = AC_SPENT;
            end else begin
                err_d = 1'b1;
            end
        end
        if (cmd_ovr) begin
            if (guard_ok) begin
                ovr_d = 1'b1;
                if (take_acc) acc_d = AC_SPENT;
            end else begin
                err_d = 1'b1;
            end
        end
        if (req_vld && use_ovr) ovr_d = 1'b0;
        if (req_vld && use_acc) acc_d = AC_SPENT;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= CS_IDLE;
            acc_q <= AC_LOCKED;
            ptr_q <= AW'(PTR_RST);
            ovr_q <= 1'b0;
            sel_q <= 1'b0;
        end else begin
            cmd_q <= cmd_d;
            acc_q <= acc_d;
            ptr_q <= ptr_d;
            ovr_q <= ovr_d;
            sel_q <= sel;
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gnt     <= 1'b0;
            deny    <= 1'b0;
            rd_vld  <= 1'b0;
            rd_ptr  <= '0;
            key_err <= 1'b0;
        end else begin
            gnt     <= req_vld && allow;
            deny    <= req_vld && !allow;
            rd_vld  <= cmd_rptr;
            key_err <= err_d;
            if (cmd_rptr) rd_ptr <= ptr_q;
        end
    end
endmodule

// File: rtl/seg_guard_chk.sv
module seg_guard_chk
    import seg_guard_pkg::*;
#(
    parameter int AW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sel,
    input logic          req_vld,
    input logic [AW-1:0] req_addr,
    input logic          cmd_wptr,
    input logic          cmd_ovr,
    input logic          cmd_load,
    input logic          cmd_rptr,
    input logic          code_end,
    input logic          gnt,
    input logic          deny,
    input logic          rd_vld,
    input logic [AW-1:0] rd_ptr,
    input logic          key_err,
    input logic          secure,
    input logic [AW-1:0] ptr_q,
    input logic          ovr_q,
    input acc_st_e       acc_q,
    input cmd_st_e       cmd_q
);
    p_one_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> (gnt != deny));

    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!gnt && !deny));

    p_below_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_addr < ptr_q && !ovr_q) |=> deny);

    p_open_unprot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !secure && req_addr >= ptr_q) |=> gnt);

    p_secure_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && secure && acc_q == AC_LOCKED && req_addr >= ptr_q) |=> deny);

    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wptr |=> $stable(ptr_q));

    p_ovr_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_addr < ptr_q && ovr_q && !cmd_ovr) |=> (gnt && !ovr_q));

    p_guard_wptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wptr && secure && acc_q == AC_LOCKED) |=> ($stable(ptr_q) && key_err));

    p_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rptr |=> (rd_vld && rd_ptr == $past(ptr_q)));

    p_spent_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q == AC_SPENT && $fell(sel) && !(cmd_q == CS_MATCH && code_end)
         && !cmd_wptr && !cmd_ovr && !cmd_load && !req_vld)
        |=> acc_q == AC_LOCKED);
endmodule

bind seg_guard seg_guard_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .req_vld(req_vld), .req_addr(req_addr),
    .cmd_wptr(cmd_wptr), .cmd_ovr(cmd_ovr), .cmd_load(cmd_load), .cmd_rptr(cmd_rptr),
    .code_end(code_end), .gnt(gnt), .deny(deny), .rd_vld(rd_vld), .rd_ptr(rd_ptr),
    .key_err(key_err), .secure(secure), .ptr_q(ptr_q), .ovr_q(ovr_q),
    .acc_q(acc_q), .cmd_q(cmd_q)
);

// File: tb/tb_seg_guard.sv
`timescale 1ns/1ps
module tb_seg_guard;
    localparam int AW = 11;
    localparam int NB = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b1;
    logic cmd_enac = 0, cmd_load = 0, code_vld = 0, code_end = 0;
    logic [7:0] code_byte = '0;
    logic cmd_wptr = 0, cmd_ovr = 0, cmd_rptr = 0, req_vld = 0;
    logic [AW-1:0] wptr_val = '0, req_addr = '0;
    logic gnt, deny, rd_vld, secure, key_err;
    logic [AW-1:0] rd_ptr;

    always #2.5 clk = ~clk;

    seg_guard #(.AW(AW), .CODE_BYTES(NB), .PTR_RST(0)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .cmd_enac(cmd_enac), .cmd_load(cmd_load),
        .code_vld(code_vld), .code_byte(code_byte), .code_end(code_end),
        .cmd_wptr(cmd_wptr), .wptr_val(wptr_val), .cmd_ovr(cmd_ovr), .cmd_rptr(cmd_rptr),
        .req_vld(req_vld), .req_addr(req_addr), .gnt(gnt), .deny(deny),
        .rd_vld(rd_vld), .rd_ptr(rd_ptr), .secure(secure), .key_err(key_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the stored state.
    int m_ptr = 0;
    int m_len = 0;
    logic [7:0] m_code [NB];
    int m_acc = 0;   // 0 locked, 1 open, 2 spent
    bit m_ovr = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit f_allow(input int a);
        if (a < m_ptr) return m_ovr;
        if (m_len == 0) return 1'b1;
        return m_acc != 0;
    endfunction

    function automatic bit f_guard_ok();
        return (m_len == 0) || (m_acc != 0);
    endfunction

    function automatic logic [127:0] f_code_bytes();
        logic [127:0] bv = '0;
        for (int i = 0; i < NB; i++) bv[8*i +: 8] = m_code[i];
        return bv;
    endfunction

    task automatic do_req(input int a, input string tag);
        bit exp, below;
        exp = f_allow(a);
        below = a < m_ptr;
        req_vld = 1; req_addr = AW'(a);
        @(negedge clk);
        req_vld = 0;
        chk(gnt == exp && deny == !exp, tag, {gnt, deny}, {exp, !exp});
        if (exp && below) m_ovr = 0;
        if (exp && !below && m_len != 0) m_acc = 2;
    endtask

    task automatic do_wptr(input int v, input string tag);
        bit ok;
        ok = f_guard_ok();
        cmd_wptr = 1; wptr_val = AW'(v);
        @(negedge clk);
        cmd_wptr = 0;
        chk(key_err == !ok, tag, key_err, !ok);
        if (ok) begin
            m_ptr = v;
            if (m_len != 0) m_acc = 2;
        end
    endtask

    task automatic do_ovr(input string tag);
        bit ok;
        ok = f_guard_ok();
        cmd_ovr = 1;
        @(negedge clk);
        cmd_ovr = 0;
        chk(key_err == !ok, tag, key_err, !ok);
        if (ok) begin
            m_ovr = 1;
            if (m_len != 0) m_acc = 2;
        end
    endtask

    task automatic do_rptr(input string tag);
        cmd_rptr = 1;
        @(negedge clk);
        cmd_rptr = 0;
        chk(rd_vld && int'(rd_ptr) == m_ptr, tag, int'(rd_ptr), m_ptr);
    endtask

    task automatic send_bytes(input logic [127:0] bv, input int n);
        for (int i = 0; i < n; i++) begin
            code_vld = 1; code_byte = bv[8*i +: 8];
            @(negedge clk);
        end
        code_vld = 0;
        code_end = 1;
        @(negedge clk);
        code_end = 0;
    endtask

    task automatic do_enac(input logic [127:0] bv, input int n, input string tag);
        bit match, experr;
        match = (m_len != 0) && (n == m_len);
        for (int i = 0; i < NB; i++)
            if (i < m_len && i < n && bv[8*i +: 8] != m_code[i]) match = 0;
        cmd_enac = 1;
        @(negedge clk);
        cmd_enac = 0;
        send_bytes(bv, n);
        experr = (m_len != 0) && !match;
        if (m_len != 0) m_acc = match ? 1 : 0;
        chk(key_err == experr, tag, key_err, experr);
    endtask

    task automatic do_load(input logic [127:0] bv, input int n, input string tag);
        bit ok, experr;
        ok = f_guard_ok();
        cmd_load = 1;
        @(negedge clk);
        cmd_load = 0;
        chk(key_err == !ok, tag, key_err, !ok);
        if (!ok) return;
        if (m_len != 0) m_acc = 2;
        send_bytes(bv, n);
        experr = n > NB;
        if (!experr) begin
            m_len = n;
            for (int i = 0; i < NB; i++) if (i < n) m_code[i] = bv[8*i +: 8];
        end
        chk(key_err == experr && secure == (m_len != 0), tag,
            {key_err, secure}, {experr, m_len != 0});
    endtask

    task automatic end_sel();
        sel = 0;
        @(negedge clk);
        sel = 1;
        if (m_acc == 2) m_acc = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [127:0] bv;
        for (int i = 0; i < NB; i++) m_code[i] = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: factory defaults
        chk(!gnt && !deny && !secure && !key_err, "R1 reset outputs", {gnt, deny, secure, key_err}, 0);
        do_rptr("R1 reset pointer");
        do_req(0, "R1 unprotected at reset");

        // R4, R6, R9: boundary in unprotected mode
        do_wptr(100, "R6 pointer write");
        do_rptr("R9 readback");
        do_req(50, "R4 below pointer");
        do_req(100, "R4 at pointer");
        do_req(2047, "R4 top address");

        // R7: one-shot override
        do_ovr("R7 arm override");
        do_req(50, "R7 override write");
        do_req(60, "R7 second below write");
        do_req(150, "R4 above pointer");

        // R2: three-byte code
        do_load(128'h33_22_11, 3, "R2 load three bytes");
        do_req(200, "R5 locked secure request");
        do_wptr(10, "R8 pointer write refused");
        do_rptr("R8 pointer unchanged");
        do_ovr("R8 override refused");
        do_req(50, "R8 below still closed");
        do_load(128'h0, 0, "R8 load refused");

        // R10: failing compares
        do_enac(128'h33_99_11, 3, "R10 wrong byte");
        do_enac(128'h22_11, 2, "R10 short count");
        do_enac(128'h44_33_22_11, 4, "R10 long count");
        do_req(200, "R10 still locked");

        // R5, R11: access window
        do_enac(f_code_bytes(), m_len, "R10 correct code");
        do_req(200, "R5 open request");
        do_req(300, "R5 same instruction");
        end_sel();
        do_req(200, "R11 cleared after use");
        do_enac(f_code_bytes(), m_len, "R10 correct again");
        end_sel();
        do_req(200, "R11 unused access kept");
        end_sel();

        // R8 with access, R7 in secure mode
        do_enac(f_code_bytes(), m_len, "R8 open for pointer");
        do_wptr(500, "R8 pointer write accepted");
        do_rptr("R6 pointer moved");
        end_sel();
        do_enac(f_code_bytes(), m_len, "R8 open for override");
        do_ovr("R7 secure override");
        end_sel();
        do_req(400, "R7 secure override write");
        do_req(400, "R7 override consumed");

        // R12: overlong load keeps old code
        do_enac(f_code_bytes(), m_len, "R12 open");
        do_load(128'h99_88_77_66_55_44_33_22_11, 9, "R12 nine bytes");
        end_sel();
        do_enac(f_code_bytes(), m_len, "R12 old code works");

        // R2: eight-byte code
        do_load(128'hF8_E7_D6_C5_B4_A3_92_81, 8, "R2 load eight bytes");
        end_sel();
        do_enac(f_code_bytes(), m_len, "R2 eight-byte compare");
        do_enac(128'hF8_E7_D6_C5_B4_A3_92_80, 8, "R10 last byte wrong");

        // R3: zero length disables
        do_enac(f_code_bytes(), m_len, "R3 open");
        do_load(128'h0, 0, "R3 zero-length load");
        do_req(600, "R3 open after clear");
        end_sel();

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            op = $urandom_range(0, 99);
            if (op < 35) begin
                int a;
                a = ($urandom_range(0, 1) == 1) ? $urandom_range(0, 2047)
                                                : m_ptr + $urandom_range(0, 6) - 3;
                if (a < 0) a = 0;
                if (a > 2047) a = 2047;
                do_req(a, "R4 R5 random request");
            end else if (op < 45) begin
                do_wptr($urandom_range(0, 2047), "R6 R8 random pointer");
            end else if (op < 52) begin
                do_ovr("R7 R8 random override");
            end else if (op < 57) begin
                do_rptr("R9 random readback");
            end else if (op < 80) begin
                bv = f_code_bytes();
                if (m_len == 0 || $urandom_range(0, 9) < 3) begin
                    int n;
                    n = $urandom_range(0, 9);
                    bv[8*$urandom_range(0, 7) +: 8] = 8'($urandom);
                    do_enac(bv, n, "R10 random compare");
                end else begin
                    do_enac(bv, m_len, "R10 random compare");
                end
            end else if (op < 88) begin
                int n;
                bv = {$urandom, $urandom, $urandom, $urandom};
                n = $urandom_range(0, 19);
                n = (n == 0) ? 0 : (n > 17) ? 9 : 1 + (n % NB);
                do_load(bv, n, "R2 R3 R12 random load");
            end else begin
                end_sel();
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule